// File: doc/BRIEF.md
# Sample Demultiplexer with Data-Ready Strobe

This block accepts one 11-bit converter sample on every clock. A sample is a 10-bit code plus an out-of-range flag. The block distributes the samples over four parallel output ports, A to D, so each port carries a fraction of the input rate. A ratio control selects two active ports (A and B) or all four. An update-mode control selects one of two behaviours. In grouped mode the active ports refresh together once a full group of samples has arrived. In staggered mode each port refreshes on the edge that captures its own sample.

Each sample passes through a selectable straight-binary or Gray encoder before it is captured. The choice applies to each sample on its own. The flag bit is never encoded. The block also drives a data-ready line that marks new port data. In single-edge mode only its rising edge carries meaning. In dual-edge mode both of its edges carry meaning. An asynchronous active-low reset clears the block, and its release is synchronised to the clock. A separate data-ready reset holds the phase at port A, so that the first sample accepted after its release lands on port A.

Top module: `sample_demux`

## Requirements
- R1: Every port word is 11 bits: bit 10 carries the out-of-range flag of the sample and bits 9:0 carry its code. The flag lands on the same port as its code.
- R2: With `ratio_sel`=0 (two-way), consecutive captured samples go to A, B, A, B. Ports C and D read zero from the first edge on which two-way is in effect.
- R3: With `ratio_sel`=1 (four-way), consecutive captured samples go to A, B, C, D, A and so on, so each port carries every fourth sample.
- R4: With `stagger_sel`=0 (grouped), all active ports change on the edge that captures the last sample of a group, and port A holds the oldest sample of the group. Between those edges every port keeps its value.
- R5: With `stagger_sel`=1 (staggered), a port changes on the same edge that captures its sample, and the other ports keep their values.
- R6: With `dr_mode_sel`=0 (single-edge), `dr_out` rises on the edge that completes a group. It stays high for half a group period (2 cycles in four-way, 1 cycle in two-way) and is low otherwise. It stays low until the first group after a data-ready reset completes.
- R7: With `dr_mode_sel`=1 (dual-edge), `dr_out` toggles on every edge that completes a group.
- R8: With `gray_sel`=1 on the cycle a sample is presented, its code is stored as b ^ (b >> 1). With `gray_sel`=0 the code is stored unchanged. Bit 10 is never encoded.
- R9: Driving `rst_n` low clears all ports, `dr_out` and the phase at once, without waiting for a clock edge. Normal operation resumes on the second rising edge after `rst_n` returns high.
- R10: While `dr_rst_n` is low, no sample is captured, the ports hold their values and `dr_out` is low. The sample presented on the first edge with `dr_rst_n` high goes to port A.
- R11: On an edge where `ratio_sel` or `stagger_sel` differs from its value on the previous edge, the sample presented goes to port A and starts a new group. Any partly filled group is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_rst_n | input | 1 | Active-low data-ready reset, sampled on the clock |
| smp_data | input | 10 | Sample code, binary |
| smp_ovr | input | 1 | Out-of-range flag of the sample |
| ratio_sel | input | 1 | 0 = two-way, 1 = four-way |
| stagger_sel | input | 1 | 0 = grouped update, 1 = staggered update |
| dr_mode_sel | input | 1 | 0 = single-edge data-ready, 1 = dual-edge |
| gray_sel | input | 1 | 1 = Gray-encode this sample |
| port_a | output | 11 | Output port A {flag, code} |
| port_b | output | 11 | Output port B |
| port_c | output | 11 | Output port C |
| port_d | output | 11 | Output port D |
| dr_out | output | 1 | Data-ready strobe |

## Verification
The hardest case to reach from the ports is a reconfiguration in the middle of a group. A correct design must discard held but unpublished samples and restart at port A. To reach it, the stimulus releases the data-ready reset in four-way grouped mode and feeds two samples. It then flips the ratio on the same cycle as the third sample. The bench checks that port A receives that third sample, that ports C and D clear, and that neither of the first two samples is ever published. A second hard case is the single-edge strobe shape across consecutive groups. The bench feeds eight samples back to back and checks `dr_out` after every capture.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;

  localparam int unsigned SDMX_LANES = 4;

  typedef enum logic {
    FMT_BIN  = 1'b0,
    FMT_GRAY = 1'b1
  } fmt_e;

  typedef enum logic {
    UPD_GROUP   = 1'b0,
    UPD_STAGGER = 1'b1
  } upd_e;

  typedef enum logic {
    DRDY_SINGLE = 1'b0,
    DRDY_DUAL   = 1'b1
  } drdy_e;

endpackage

// File: rtl/sdmx_fmt.sv
module sdmx_fmt
  import sdmx_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic [DATA_W-1:0] code_in,
  input  logic              ovr_in,
  input  fmt_e              fmt,
  output logic [DATA_W:0]   word_out
);

  logic [DATA_W-1:0] gray_code;

  always_comb begin
    gray_code = code_in ^ (code_in >> 1);
    if (fmt == FMT_GRAY) begin
      word_out = {ovr_in, gray_code};
    end else begin
      word_out = {ovr_in, code_in};
    end
  end

endmodule

// File: rtl/sdmx_phase.sv
module sdmx_phase
  import sdmx_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned PH_W = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            wide,
  input  upd_e            upd,
  output logic [PH_W-1:0] slot,
  output logic            last
);

  localparam logic [PH_W-1:0] LAST_FULL = PH_W'(LANES - 1);
  localparam logic [PH_W-1:0] LAST_HALF = PH_W'(LANES / 2 - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            wide_q;
  upd_e            upd_q;
  logic            cfg_chg;
  logic [PH_W-1:0] last_idx;

  always_comb begin
    last_idx = wide ? LAST_FULL : LAST_HALF;
    cfg_chg  = (wide != wide_q) || (upd != upd_q);
    slot     = cfg_chg ? '0 : ph_q;
    last     = (slot == last_idx);
    if (!run) begin
      ph_d = '0;
    end else if (last) begin
      ph_d = '0;
    end else begin
      ph_d = slot + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      wide_q <= 1'b0;
      upd_q  <= UPD_GROUP;
    end else begin
      ph_q   <= ph_d;
      wide_q <= wide;
      upd_q  <= upd;
    end
  end

endmodule

// File: rtl/sdmx_lanes.sv
module sdmx_lanes
  import sdmx_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 11,
  localparam int unsigned PH_W  = $clog2(LANES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic [WORD_W-1:0]            word,
  input  logic [PH_W-1:0]              slot,
  input  logic                         last,
  input  logic                         wide,
  input  upd_e                         upd,
  output logic [LANES-1:0][WORD_W-1:0] lane_q
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit UPPER = (i >= LANES / 2);

    logic [WORD_W-1:0] hold_q, hold_d, out_q, out_d;
    logic              hold_en, out_en, hit, active;

    always_comb begin
      active  = UPPER ? wide : 1'b1;
      hit     = run && (slot == PH_W'(i));
      hold_en = hit && (upd == UPD_GROUP);
      hold_d  = word;
      if (!active) begin
        out_en = 1'b1;
        out_d  = '0;
      end else if (upd == UPD_STAGGER) begin
        out_en = hit;
        out_d  = word;
      end else begin
        out_en = run && last;
        out_d  = hit ? word : hold_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (hold_en) begin
        hold_q <= hold_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
      end else if (out_en) begin
        out_q <= out_d;
      end
    end

    assign lane_q[i] = out_q;
  end

endmodule

// File: rtl/sdmx_dready.sv
module sdmx_dready
  import sdmx_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned PH_W = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            wide,
  input  drdy_e           mode,
  input  logic [PH_W-1:0] slot,
  input  logic            last,
  output logic            dr_q
);

  localparam int unsigned CW = PH_W + 1;

  logic [CW-1:0] half_grp;
  logic          extend;
  logic          dr_d;

  always_comb begin
    half_grp = wide ? CW'(LANES / 2) : CW'(LANES / 4);
    extend   = (CW'(slot) + CW'(1)) < half_grp;
    if (!run) begin
      dr_d = 1'b0;
    end else if (mode == DRDY_DUAL) begin
      dr_d = dr_q ^ last;
    end else begin
      dr_d = last || (extend && dr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
    end else begin
      dr_q <= dr_d;
    end
  end

endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import sdmx_pkg::*;
#(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_rst_n,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  input  logic              ratio_sel,
  input  logic              stagger_sel,
  input  logic              dr_mode_sel,
  input  logic              gray_sel,
  output logic [DATA_W:0]   port_a,
  output logic [DATA_W:0]   port_b,
  output logic [DATA_W:0]   port_c,
  output logic [DATA_W:0]   port_d,
  output logic              dr_out
);

  localparam int unsigned LANES  = SDMX_LANES;
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned PH_W   = $clog2(LANES);

  logic [SYNC_STAGES-1:0]       rst_pipe_q;
  logic                         rst_int_n;
  logic [WORD_W-1:0]            word;
  logic [PH_W-1:0]              slot;
  logic                         last;
  logic [LANES-1:0][WORD_W-1:0] lanes;
  upd_e                         upd;
  drdy_e                        drmode;
  fmt_e                         fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  assign upd    = upd_e'(stagger_sel);
  assign drmode = drdy_e'(dr_mode_sel);
  assign fmt    = fmt_e'(gray_sel);

  sdmx_fmt #(.DATA_W(DATA_W)) u_fmt (
    .code_in  (smp_data),
    .ovr_in   (smp_ovr),
    .fmt      (fmt),
    .word_out (word)
  );

  sdmx_phase #(.LANES(LANES)) u_phase (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (dr_rst_n),
    .wide  (ratio_sel),
    .upd   (upd),
    .slot  (slot),
    .last  (last)
  );

  sdmx_lanes #(.LANES(LANES), .WORD_W(WORD_W)) u_lanes (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (dr_rst_n),
    .word   (word),
    .slot   (slot),
    .last   (last),
    .wide   (ratio_sel),
    .upd    (upd),
    .lane_q (lanes)
  );

  sdmx_dready #(.LANES(LANES)) u_dready (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (dr_rst_n),
    .wide  (ratio_sel),
    .mode  (drmode),
    .slot  (slot),
    .last  (last),
    .dr_q  (dr_out)
  );

  assign port_a = lanes[0];
  assign port_b = lanes[1];
  assign port_c = lanes[2];
  assign port_d = lanes[3];

endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk #(
  parameter int unsigned WORD_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dr_rst_n,
  input logic              ratio_sel,
  input logic              stagger_sel,
  input logic              dr_mode_sel,
  input logic [WORD_W-1:0] port_a,
  input logic [WORD_W-1:0] port_b,
  input logic [WORD_W-1:0] port_c,
  input logic [WORD_W-1:0] port_d,
  input logic              dr_out
);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |-> (port_a == '0 && port_b == '0 && port_c == '0 && port_d == '0 && !dr_out));

  // R2
  narrow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ratio_sel) |-> (port_c == '0 && port_d == '0));

  // R10
  dr_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_rst_n |=> !dr_out);

  // R5
  stagger_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stagger_sel) && $past(ratio_sel)) |->
    ($countones({!$stable(port_a), !$stable(port_b), !$stable(port_c), !$stable(port_d)}) <= 1));

  // R6
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!stagger_sel) && $past(!dr_mode_sel) && !$stable(port_a)) |-> dr_out);

endmodule

bind sample_demux sample_demux_chk #(.WORD_W(DATA_W + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dr_rst_n    (dr_rst_n),
  .ratio_sel   (ratio_sel),
  .stagger_sel (stagger_sel),
  .dr_mode_sel (dr_mode_sel),
  .port_a      (port_a),
  .port_b      (port_b),
  .port_c      (port_c),
  .port_d      (port_d),
  .dr_out      (dr_out)
);

// File: tb/sample_demux_bench.sv
`timescale 1ns/1ps
module sample_demux_bench;

  logic        clk = 1'b0;
  logic        rst_n, dr_rst_n, smp_ovr, ratio_sel, stagger_sel, dr_mode_sel, gray_sel;
  logic [9:0]  smp_data;
  logic [10:0] port_a, port_b, port_c, port_d;
  logic        dr_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sample_demux u_sample_demux (
    .clk(clk), .rst_n(rst_n), .dr_rst_n(dr_rst_n), .smp_data(smp_data), .smp_ovr(smp_ovr),
    .ratio_sel(ratio_sel), .stagger_sel(stagger_sel), .dr_mode_sel(dr_mode_sel),
    .gray_sel(gray_sel), .port_a(port_a), .port_b(port_b), .port_c(port_c),
    .port_d(port_d), .dr_out(dr_out)
  );

  typedef struct packed {
    logic       r4;
    logic       stg;
    logic       dual;
    logic       gray;
    logic [3:0] mask;
    logic [9:0] seed;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 10'h155},
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'b0010, 10'h3FF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 10'h000},
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'b0101, 10'h2AA},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'b1111, 10'h1C3},
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 10'h3F0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'b0011, 10'h200},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0110, 10'h0FF}
  };

  function automatic logic [9:0] to_gray(input logic [9:0] b);
    logic [9:0] g;
    for (int i = 0; i < 10; i++) g[i] = (i == 9) ? b[9] : (b[i] ^ b[i+1]);
    return g;
  endfunction

  function automatic logic [10:0] port_of(input int i);
    case (i)
      0: return port_a;
      1: return port_b;
      2: return port_c;
      default: return port_d;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] d, input logic o);
    smp_data = d;
    smp_ovr  = o;
  endtask

  // Set config under data-ready reset, then release on the next negedge.
  task automatic restart(input logic r4, input logic stg, input logic dual, input logic g);
    @(negedge clk);
    dr_rst_n = 1'b0; ratio_sel = r4; stagger_sel = stg; dr_mode_sel = dual; gray_sel = g;
    @(negedge clk);
    dr_rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dr_rst_n = 1'b0; smp_data = '0; smp_ovr = 1'b0;
    ratio_sel = 1'b0; stagger_sel = 1'b0; dr_mode_sel = 1'b0; gray_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset A", port_a, 0); check("R9 reset B", port_b, 0);
    check("R9 reset C", port_c, 0); check("R9 reset D", port_d, 0);
    check("R9 reset dr", dr_out, 0);

    // Table walk: R1 R2 R3 R4 R5 R7 R8 R10
    for (int r = 0; r < NROWS; r++) begin
      row_t row;
      int   n;
      row = ROWS[r];
      n   = row.r4 ? 4 : 2;
      restart(row.r4, row.stg, row.dual, row.gray);
      for (int k = 0; k < n; k++) begin
        if (k > 0) @(negedge clk);
        put(row.seed + 10'(k * 73), row.mask[k]);
      end
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        logic [9:0]  raw;
        logic [10:0] exp;
        raw = row.seed + 10'(i * 73);
        exp = (i < n) ? {row.mask[i], (row.gray ? to_gray(raw) : raw)} : 11'h0;
        check($sformatf("R1 R2 R3 R8 R10 row %0d port %0d", r, i), port_of(i), exp);
      end
      check($sformatf("R6 R7 row %0d dr", r), dr_out, 1);
      dr_rst_n = 1'b0;
    end

    // R9 asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async A", port_a, 0); check("R9 async D", port_d, 0);
    check("R9 async dr", dr_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 staggered partial group
    restart(1'b1, 1'b1, 1'b0, 1'b0);
    put(10'h123, 1'b0);
    @(negedge clk);
    check("R5 stagger A", port_a, 11'h123); check("R5 stagger B", port_b, 0);
    put(10'h0AB, 1'b1);
    @(negedge clk);
    check("R5 stagger B2", port_b, 11'h4AB); check("R5 stagger C", port_c, 0);

    // R4 grouped hold, then R6 strobe shape over two groups
    restart(1'b1, 1'b0, 1'b0, 1'b0);
    begin
      logic exp_dr [8] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
      for (int k = 0; k < 8; k++) begin
        put(10'h010 + 10'(k), 1'b0);
        @(negedge clk);
        check($sformatf("R6 single dr step %0d", k), dr_out, exp_dr[k]);
        if (k == 1) check("R4 hold A", port_a, 11'h123);
        if (k == 3) begin
          check("R4 group A", port_a, 11'h010); check("R4 group D", port_d, 11'h013);
        end
      end
    end

    // R6 single-edge in two-way
    restart(1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      put(10'h020 + 10'(k), 1'b0);
      @(negedge clk);
      check($sformatf("R6 two-way dr step %0d", k), dr_out, (k % 2 == 1) ? 1 : 0);
    end

    // R7 dual-edge over two groups
    restart(1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      put(10'h030 + 10'(k), 1'b0);
      @(negedge clk);
      if (k == 3) check("R7 dual first", dr_out, 1);
      if (k == 4) check("R7 dual hold", dr_out, 1);
      if (k == 7) check("R7 dual second", dr_out, 0);
    end

    // R11 reconfiguration mid-group
    restart(1'b1, 1'b0, 1'b0, 1'b0);
    put(10'h011, 1'b0);
    @(negedge clk); put(10'h022, 1'b0);
    @(negedge clk); ratio_sel = 1'b0; put(10'h033, 1'b0);
    @(negedge clk); put(10'h044, 1'b0);
    @(negedge clk);
    check("R11 restart A", port_a, 11'h033); check("R11 restart B", port_b, 11'h044);
    check("R11 R2 C zero", port_c, 0); check("R11 R2 D zero", port_d, 0);

    // R8 per-sample format choice, flag left plain
    restart(1'b0, 1'b0, 1'b0, 1'b0);
    put(10'h2D3, 1'b0);
    @(negedge clk); gray_sel = 1'b1; put(10'h2D3, 1'b1);
    @(negedge clk);
    check("R8 binary A", port_a, 11'h2D3);
    check("R8 gray B", port_b, {1'b1, to_gray(10'h2D3)});

    // R10 no capture while held, first after release to A
    @(negedge clk);
    dr_rst_n = 1'b0; ratio_sel = 1'b1; stagger_sel = 1'b1; gray_sel = 1'b0; put(10'h3AB, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 held A", port_a, 11'h2D3);
    check("R10 held dr", dr_out, 0);
    dr_rst_n = 1'b1; put(10'h155, 1'b0);
    @(negedge clk);
    check("R10 first to A", port_a, 11'h155);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule